// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by fixed priority and, when the processor acknowledges, hands back an 8-bit vector that identifies the winning line. Software reaches it through two addresses. The command address takes control words. The data address takes the interrupt mask and, right after an initialization start, the setup words.

An initialization start is any command write with bit 4 set. It is followed by data writes carrying, in this order, the vector base, the cascade word and an optional mode word. The mode word is sent only when bit 0 of the start word requested it. Once running, the block keeps three 8-bit registers: a request register, an in-service register and a mask register. Software can read each of them back. In-service levels are retired either by a specific end-of-interrupt command or automatically at acknowledge, as the mode word selects. If an acknowledge arrives with nothing eligible to serve, the block answers with the level-7 vector and changes no state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A command write with bit 4 set starts initialization. The next data writes are taken as the base word, then the cascade word, then the mode word only if bit 0 of the start word was 1. After that, data writes load the mask.
- R2: The acknowledged vector is the base word's bits 7:3 joined with the 3-bit number of the winning level.
- R3: A data write outside initialization sets the mask. A data-address read returns it. A mask bit of 1 keeps that level from raising int_out or winning an acknowledge.
- R4: A command write of 0x0A makes command-address reads return the request register. A write of 0x0B makes them return the in-service register. The choice holds until it is changed.
- R5: A command write of 0x60+n (n in 0..7) clears in-service bit n only.
- R6: When mode-word bit 1 is 1 (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R7: An acknowledge while int_out is low returns the base with level 7 and leaves the request and in-service registers unchanged. This applies even when level 7 is masked.
- R8: Level 0 has the highest priority and level 7 the lowest. int_out is high only when an unmasked request exists whose level is above every in-service level.
- R9: A request bit is set by a rising edge on its input and cleared by the acknowledge that serves it. An input held high does not request again.
- R10: Reset, and every initialization start, clears the in-service and mask registers and selects the request register for read-back.
- R11: The cascade word written during initialization appears on cascade_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 selects the command address, 1 selects the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| int_out | output | 1 | Interrupt pending to the processor |
| inta | input | 1 | Single-cycle acknowledge pulse |
| vec_out | output | 8 | Vector, valid in the inta cycle |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The bench uses the default parameters: eight levels and an 8-bit data path. With these, the three low vector bits cover every level and the five upper bits take the programmed base. The bench programs two different bases (0x20 and 0x40), so a fault that drops base bits or mixes them with level bits changes a checked vector. With all eight levels present, the bench can also reach the lowest-priority spurious case and in-service blocking between levels that are not adjacent.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_LEVELS = 8;
    localparam int PIC_DW     = 8;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CAS,
        ST_MODE
    } init_st_e;

    typedef enum logic {
        SEL_REQ,
        SEL_SVC
    } rdsel_e;

    localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
    localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
    localparam logic [4:0] CMD_EOI_HI  = 5'b01100;

    typedef struct packed {
        logic       start;
        logic       sel_req;
        logic       sel_svc;
        logic       eoi;
        logic [2:0] lvl;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic wr, input logic [7:0] d);
        cmd_dec_t c;
        c.start   = wr && d[4];
        c.sel_req = wr && (d == CMD_SEL_REQ);
        c.sel_svc = wr && (d == CMD_SEL_SVC);
        c.eoi     = wr && (d[7:3] == CMD_EOI_HI);
        c.lvl     = d[2:0];
        return c;
    endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int DW = PIC_DW,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] imr,
    output logic [DW-LW-1:0] base,
    output logic [DW-1:0] cascade,
    output logic          aeoi,
    output rdsel_e        rdsel,
    output logic          init_clr,
    output logic          eoi_vld,
    output logic [LW-1:0] eoi_lvl
);
    cmd_dec_t cmd;
    init_st_e st_q;
    logic     need_mode_q;

    assign cmd      = decode_cmd(cmd_wr, wdata);
    assign init_clr = cmd.start;
    assign eoi_vld  = cmd.eoi && !cmd.start;
    assign eoi_lvl  = cmd.lvl[LW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_READY;
            need_mode_q <= 1'b0;
            imr         <= '0;
            base        <= '0;
            cascade     <= '0;
            aeoi        <= 1'b0;
            rdsel       <= SEL_REQ;
        end else if (cmd.start) begin
            st_q        <= ST_BASE;
            need_mode_q <= wdata[0];
            imr         <= '0;
            aeoi        <= 1'b0;
            rdsel       <= SEL_REQ;
        end else begin
            if (cmd.sel_req) rdsel <= SEL_REQ;
            if (cmd.sel_svc) rdsel <= SEL_SVC;
            if (dat_wr) begin
                unique case (st_q)
                    ST_BASE: begin
                        base <= wdata[DW-1:LW];
                        st_q <= ST_CAS;
                    end
                    ST_CAS: begin
                        cascade <= wdata;
                        st_q    <= need_mode_q ? ST_MODE : ST_READY;
                    end
                    ST_MODE: begin
                        aeoi <= wdata[1];
                        st_q <= ST_READY;
                    end
                    default: imr <= wdata;
                endcase
            end
        end
    end

    a_r10_init_clears_mask: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> (imr == '0) && (rdsel == SEL_REQ));
    a_r1_base_then_cascade: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !cmd.start && st_q == ST_BASE) |=> (st_q == ST_CAS));
endmodule

// File: rtl/pic_req_svc.sv
module pic_req_svc
#(
    parameter int NLEV = 8,
    parameter int LW   = $clog2(NLEV)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NLEV-1:0] irq_in,
    input  logic            grant,
    input  logic [LW-1:0]   win_lvl,
    input  logic            aeoi,
    input  logic            init_clr,
    input  logic            eoi_vld,
    input  logic [LW-1:0]   eoi_lvl,
    output logic [NLEV-1:0] irr,
    output logic [NLEV-1:0] isr
);
    logic [NLEV-1:0] prev_q, rise, win_1h, eoi_1h;

    assign rise   = irq_in & ~prev_q;
    assign win_1h = grant ? (NLEV'(1) << win_lvl) : '0;
    assign eoi_1h = eoi_vld ? (NLEV'(1) << eoi_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr    <= '0;
            isr    <= '0;
        end else begin
            prev_q <= irq_in;
            irr    <= (irr & ~win_1h) | rise;
            if (init_clr)
                isr <= '0;
            else
                isr <= (isr & ~eoi_1h) | (aeoi ? '0 : win_1h);
        end
    end

    a_r5_eoi_clears_level: assert property (@(posedge clk) disable iff (rst)
        (eoi_vld && !grant && !init_clr) |=> !isr[$past(eoi_lvl)]);
    a_r6_aeoi_sets_nothing: assert property (@(posedge clk) disable iff (rst)
        (grant && aeoi) |=> ((isr & ~$past(isr)) == '0));
    a_r8_one_new_svc_bit: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(isr & ~$past(isr)));
    a_r8_svc_needs_grant: assert property (@(posedge clk) disable iff (rst)
        !grant |=> ((isr & ~$past(isr)) == '0));
    a_r10_init_clears_svc: assert property (@(posedge clk) disable iff (rst)
        init_clr |=> (isr == '0));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
#(
    parameter int NLEV = 8,
    parameter int LW   = $clog2(NLEV)
) (
    input  logic [NLEV-1:0] irr,
    input  logic [NLEV-1:0] imr,
    input  logic [NLEV-1:0] isr,
    output logic            int_req,
    output logic [LW-1:0]   win_lvl
);
    logic [NLEV-1:0] cand;
    logic [LW-1:0]   svc_lvl;
    logic            cand_any, svc_any;

    assign cand = irr & ~imr;

    always_comb begin
        win_lvl  = '0;
        svc_lvl  = '0;
        cand_any = 1'b0;
        svc_any  = 1'b0;
        for (int i = NLEV - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_lvl  = LW'(i);
                cand_any = 1'b1;
            end
            if (isr[i]) begin
                svc_lvl = LW'(i);
                svc_any = 1'b1;
            end
        end
        int_req = cand_any && (!svc_any || (win_lvl < svc_lvl));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NLEV = PIC_LEVELS,
    parameter int DW   = PIC_DW,
    localparam int LW  = $clog2(NLEV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NLEV-1:0] irq_in,
    output logic          int_out,
    input  logic          inta,
    output logic [DW-1:0] vec_out,
    output logic [DW-1:0] cascade_cfg
);
    logic [DW-1:0]    imr;
    logic [DW-LW-1:0] base;
    logic             aeoi, init_clr, eoi_vld, grant;
    logic [LW-1:0]    eoi_lvl, win_lvl;
    rdsel_e           rdsel;
    logic [NLEV-1:0]  irr, isr;

    pic_cfg_regs #(.DW(DW), .LW(LW)) u_cfg (
        .clk(clk), .rst(rst),
        .cmd_wr(bus_wr && !bus_addr), .dat_wr(bus_wr && bus_addr),
        .wdata(bus_wdata), .imr(imr), .base(base), .cascade(cascade_cfg),
        .aeoi(aeoi), .rdsel(rdsel), .init_clr(init_clr),
        .eoi_vld(eoi_vld), .eoi_lvl(eoi_lvl)
    );

    pic_resolver #(.NLEV(NLEV), .LW(LW)) u_res (
        .irr(irr), .imr(imr[NLEV-1:0]), .isr(isr),
        .int_req(int_out), .win_lvl(win_lvl)
    );

    assign grant = inta && int_out;

    pic_req_svc #(.NLEV(NLEV), .LW(LW)) u_rs (
        .clk(clk), .rst(rst), .irq_in(irq_in), .grant(grant),
        .win_lvl(win_lvl), .aeoi(aeoi), .init_clr(init_clr),
        .eoi_vld(eoi_vld), .eoi_lvl(eoi_lvl), .irr(irr), .isr(isr)
    );

    assign vec_out   = {base, grant ? win_lvl : LW'(NLEV - 1)};
    assign bus_rdata = bus_addr ? imr :
                       (rdsel == SEL_SVC ? DW'(isr) : DW'(irr));

    a_r3_int_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr[NLEV-1:0]) != '0));
    a_r7_spurious_state_kept: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_out && !init_clr && !eoi_vld) |=> $stable(isr));
    a_r7_spurious_vector: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_out) |-> (vec_out[LW-1:0] == LW'(NLEV - 1)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_addr = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic [7:0] bus_rdata, vec_out, cascade_cfg;
    logic       int_out;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .inta(inta), .vec_out(vec_out),
        .cascade_cfg(cascade_cfg)
    );

    // {pulse pattern, mask, expected vector} with base 0x20
    localparam logic [23:0] TBL [6] = '{
        {8'h01, 8'h00, 8'h20},
        {8'h80, 8'h00, 8'h27},
        {8'h84, 8'h00, 8'h22},
        {8'h06, 8'h02, 8'h22},
        {8'hF0, 8'h10, 8'h25},
        {8'h18, 8'h08, 8'h24}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #5 d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] p);
        @(negedge clk); irq_in = p;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk); inta = 1'b1;
        #5 v = vec_out;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic intq(output logic [7:0] v);
        @(negedge clk); #5 v = {7'b0, int_out};
    endtask

    task automatic drain();
        logic [7:0] v;
        wr(1'b1, 8'h00);
        for (int k = 0; k < 8; k++) begin
            intq(v);
            if (v[0]) begin
                ack(v);
                wr(1'b0, 8'h60 | (v & 8'h07));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        intq(v); chk("R10 int after reset", v, 8'h00);
        rd(1'b1, v); chk("R10 mask after reset", v, 8'h00);
        rd(1'b0, v); chk("R10 request after reset", v, 8'h00);

        // R1 full init with mode word, normal EOI
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
        chk("R11 cascade word", cascade_cfg, 8'h04);
        wr(1'b1, 8'h81);
        rd(1'b1, v); chk("R3 R1 mask readback", v, 8'h81);
        wr(1'b1, 8'h00);

        // vector table: R2 R3 R8
        for (int i = 0; i < 6; i++) begin
            wr(1'b1, TBL[i][15:8]);
            pulse(TBL[i][23:16]);
            intq(v); chk("R3 int raised", v, 8'h01);
            ack(v); chk("R2 R8 table vector", v, TBL[i][7:0]);
            wr(1'b0, 8'h60 | (TBL[i][7:0] & 8'h07));
            drain();
        end

        // R4 read-back select
        pulse(8'h08);
        rd(1'b0, v); chk("R4 request view", v, 8'h08);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R4 service view", v, 8'h00);
        ack(v); chk("R2 level 3", v, 8'h23);
        rd(1'b0, v); chk("R4 service after ack", v, 8'h08);
        intq(v);
        rd(1'b0, v); chk("R4 select persists", v, 8'h08);

        // R8 blocking by in-service level
        pulse(8'h20);
        intq(v); chk("R8 lower level blocked", v, 8'h00);
        pulse(8'h02);
        intq(v); chk("R8 higher level passes", v, 8'h01);
        ack(v); chk("R8 level 1 vector", v, 8'h21);
        // R5 specific EOI of level 3 only
        wr(1'b0, 8'h63);
        rd(1'b0, v); chk("R5 only level 3 cleared", v, 8'h02);
        intq(v); chk("R8 level 5 blocked by 1", v, 8'h00);
        wr(1'b0, 8'h61);
        intq(v); chk("R8 level 5 now passes", v, 8'h01);
        ack(v); chk("R8 level 5 vector", v, 8'h25);
        wr(1'b0, 8'h65);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R4 back to request view", v, 8'h00);

        // R9 held input requests once
        @(negedge clk); irq_in = 8'h04;
        intq(v);
        ack(v); chk("R9 held level 2 vector", v, 8'h22);
        wr(1'b0, 8'h62);
        rd(1'b0, v); chk("R9 no re-request", v, 8'h00);
        intq(v); chk("R9 int low while held", v, 8'h00);
        @(negedge clk); irq_in = 8'h00;

        // R7 spurious acknowledge, level 7 masked
        wr(1'b1, 8'hFF);
        pulse(8'h01);
        intq(v); chk("R3 masked no int", v, 8'h00);
        wr(1'b0, 8'h0B);
        ack(v); chk("R7 spurious vector", v, 8'h27);
        rd(1'b0, v); chk("R7 service unchanged", v, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R7 request unchanged", v, 8'h01);
        drain();

        // R10 re-init without mode word clears state
        pulse(8'h01); ack(v);
        wr(1'b0, 8'h0B); wr(1'b1, 8'h55);
        wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R10 mask cleared by init", v, 8'h00);
        pulse(8'h40);
        rd(1'b0, v); chk("R10 select reset to request", v, 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R10 service cleared by init", v, 8'h00);
        wr(1'b1, 8'h02);
        rd(1'b1, v); chk("R1 no mode word then mask", v, 8'h02);
        ack(v); chk("R2 new base", v, 8'h46);
        wr(1'b0, 8'h66);
        drain();

        // R6 automatic end-of-interrupt
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        wr(1'b0, 8'h0B);
        pulse(8'h10);
        ack(v); chk("R6 vector", v, 8'h24);
        rd(1'b0, v); chk("R6 no service bit", v, 8'h00);
        pulse(8'h20);
        intq(v); chk("R6 next level unblocked", v, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule